// File: doc/BRIEF.md
# Serial Set-Bit Index Accumulator

This block takes a wide bit vector and adds up the positions of all the bits in it that are set to one. It does the work serially, one bit per clock cycle, so the adder stays narrow however wide the vector is. A one-cycle start strobe captures the vector. A shift register then moves the bits past a single examination point, and an index counter keeps track of the position being examined. When the last position has been examined, the block pulses a valid flag and presents the total.

The vector width is a parameter, and the index and sum widths are derived from it. With the default width of 1023 the index counter is 10 bits and the sum is 19 bits. Bit 0 adds nothing to the sum, so the scan begins at position 1. The block goes back to idle by itself when a scan ends. A new start strobe can be given at any time. If a scan is running, the strobe abandons it and the scan begins again with the newly captured vector.

Top module: `setbit_index_sum`

## Requirements
- R1: After synchronous reset `sum_valid` is 0 and the block is idle. No valid pulse appears until a start strobe has been given.
- R2: `vec_in` is sampled only on the rising edge where `start` is 1. Any change to `vec_in` after that edge has no effect on the result.
- R3: The result on `sum_out` is the plain binary sum of the positions i (counted from 0 at the LSB) of all bits of the captured vector that are 1. For the default width, an all-ones vector gives 522753 and an all-zeros vector gives 0.
- R4: `sum_valid` is high for exactly one cycle. That cycle starts VEC_W-1 rising edges after the edge that samples `start`, which is 1022 edges for the default width.
- R5: From the valid pulse until the next start strobe, `sum_out` holds its value.
- R6: A start strobe during a scan abandons that scan. The block produces no result for the abandoned vector. The next valid pulse carries the sum of the new vector and is timed from the new strobe as in R4.
- R7: If a start strobe falls on the edge that would complete a scan, the restart wins. No valid pulse is produced for the old vector.
- R8: Bit 0 adds nothing to the sum. A vector with only bit VEC_W-1 set gives VEC_W-1.
- R9: While the block is idle and no start strobe is given, `sum_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that captures `vec_in` and begins a scan |
| vec_in | input | VEC_W | Vector whose set-bit positions are summed |
| sum_out | output | SUM_W | Sum of set-bit positions (19 bits at the default width) |
| sum_valid | output | 1 | One-cycle pulse when `sum_out` holds a completed result |

## Verification
The two functions that can fall in the same cycle are the completion of a scan and the capture of a new vector. The bench provokes this by raising `start` on exactly the edge that would otherwise set `sum_valid`. It then judges that no pulse appears in the following cycle, and that the next pulse comes a full scan length later and carries the new vector's sum. The same cycle-accurate reference model, compared on every clock, also covers aborts in mid-scan and changes to the input after capture.

// File: rtl/setbit_pkg.sv
package setbit_pkg;

  // Number of bits needed for the index counter: positions 0 .. n-1.
  function automatic int index_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Number of bits needed to hold 0 + 1 + ... + (n-1) without overflow.
  function automatic int sum_width(input int n);
    longint total;
    int w;
    total = (longint'(n) * longint'(n - 1)) / 2;
    w = 1;
    while ((longint'(1) << w) <= total) w++;
    return w;
  endfunction

endpackage

// File: rtl/setbit_shifter.sv
// Holds the captured vector and presents one bit per cycle at bit 0.
module setbit_shifter #(
  parameter int VEC_W = 1023
) (
  input  logic             clk,
  input  logic             load,
  input  logic             step,
  input  logic [VEC_W-1:0] load_vec,
  output logic             cur_bit
);

  logic [VEC_W-1:0] shreg;

  // Loading pre-shifts by one: position 0 never contributes, so the scan
  // starts at position 1 with that bit already at the examination point.
  always_ff @(posedge clk) begin
    if (load)      shreg <= load_vec >> 1;
    else if (step) shreg <= shreg >> 1;
  end

  assign cur_bit = shreg[0];

endmodule

// File: rtl/setbit_index_counter.sv
// Tracks the position under examination; zero means idle.
module setbit_index_counter #(
  parameter int VEC_W = 1023,
  localparam int IDX_W = setbit_pkg::index_width(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_W - 1);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  assign busy = (idx != '0);
  assign last = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)        idx <= '0;
    else if (start) idx <= ONE;
    else if (last)  idx <= '0;
    else if (busy)  idx <= idx + ONE;
  end

endmodule

// File: rtl/setbit_accum.sv
// Running sum; adds the current index when the examined bit is set.
module setbit_accum #(
  parameter int VEC_W = 1023,
  localparam int IDX_W = setbit_pkg::index_width(VEC_W),
  localparam int SUM_W = setbit_pkg::sum_width(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add_en,
  input  logic [IDX_W-1:0] addend,
  output logic [SUM_W-1:0] sum
);

  logic [SUM_W-1:0] addend_ext;
  assign addend_ext = {{(SUM_W-IDX_W){1'b0}}, addend};

  always_ff @(posedge clk) begin
    if (rst || clear) sum <= '0;
    else if (add_en)  sum <= sum + addend_ext;
  end

endmodule

// File: rtl/setbit_index_sum.sv
module setbit_index_sum #(
  parameter int VEC_W = 1023,
  localparam int IDX_W = setbit_pkg::index_width(VEC_W),
  localparam int SUM_W = setbit_pkg::sum_width(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] vec_in,
  output logic [SUM_W-1:0] sum_out,
  output logic             sum_valid
);

  // Named internal events, also used by the bound checker.
  logic [IDX_W-1:0] scan_idx;
  logic             scan_busy;
  logic             scan_last;
  logic             bit_hit;
  logic             scan_step;
  logic             add_now;

  assign scan_step = scan_busy && !start;
  assign add_now   = scan_step && bit_hit;

  setbit_shifter #(.VEC_W(VEC_W)) u_shift (
    .clk      (clk),
    .load     (start),
    .step     (scan_step),
    .load_vec (vec_in),
    .cur_bit  (bit_hit)
  );

  setbit_index_counter #(.VEC_W(VEC_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .idx   (scan_idx),
    .busy  (scan_busy),
    .last  (scan_last)
  );

  setbit_accum #(.VEC_W(VEC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .add_en (add_now),
    .addend (scan_idx),
    .sum    (sum_out)
  );

  // Valid is set on the final step; a restart on that edge suppresses it.
  always_ff @(posedge clk) begin
    if (rst || start) sum_valid <= 1'b0;
    else              sum_valid <= scan_last;
  end

endmodule

// File: rtl/setbit_index_sum_chk.sv
module setbit_index_sum_chk #(
  parameter int VEC_W = 1023,
  localparam int IDX_W = setbit_pkg::index_width(VEC_W),
  localparam int SUM_W = setbit_pkg::sum_width(VEC_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sum_valid,
  input logic [SUM_W-1:0] sum_out,
  input logic             scan_busy,
  input logic             scan_last
);

  // Edges since the last start strobe, saturating; replaces a long $past.
  localparam logic [IDX_W:0] SAT = '1;
  logic [IDX_W:0] since_start;

  always_ff @(posedge clk) begin
    if (rst)                     since_start <= '0;
    else if (start)              since_start <= (IDX_W+1)'(1);
    else if (since_start != '0 && since_start != SAT)
                                 since_start <= since_start + (IDX_W+1)'(1);
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sum_valid |=> !sum_valid);

  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (since_start == (IDX_W+1)'(VEC_W)));

  a_r4_last_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (scan_last && !start) |=> sum_valid);

  a_r7_restart_wins: assert property (@(posedge clk) disable iff (rst)
    start |=> !sum_valid);

  a_r5_sum_hold: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && !start) |=> $stable(sum_out));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && !start) |=> !sum_valid);

  a_r3_no_decrease: assert property (@(posedge clk) disable iff (rst)
    (scan_busy && !start) |=> (sum_out >= $past(sum_out)));

endmodule

bind setbit_index_sum setbit_index_sum_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sum_valid (sum_valid),
  .sum_out   (sum_out),
  .scan_busy (scan_busy),
  .scan_last (scan_last)
);

// File: tb/setbit_index_sum_test.sv
`timescale 1ns/1ps
module setbit_index_sum_test;

  localparam int N  = 1023;
  localparam int SW = setbit_pkg::sum_width(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  vec_in = '0;
  logic [SW-1:0] sum_out;
  logic          sum_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  setbit_index_sum uut (
    .clk(clk), .rst(rst), .start(start), .vec_in(vec_in),
    .sum_out(sum_out), .sum_valid(sum_valid)
  );

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Software restatement: loop over positions, add each set one.
  function automatic longint soft_sum(input logic [N-1:0] v);
    longint s = 0;
    for (int i = 0; i < N; i++) if (v[i]) s += i;
    return s;
  endfunction

  function automatic logic [N-1:0] rand_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  // Behavioural cycle model: a queue of pending positions still to visit.
  int            q_pos[$];
  logic [N-1:0]  m_vec;
  longint        m_sum = 0;
  bit            m_valid = 0;
  bit            m_have = 0;

  always @(posedge clk) begin
    if (rst) begin
      q_pos.delete(); m_valid = 0; m_have = 0; m_sum = 0;
    end else if (start) begin
      q_pos.delete();
      for (int i = 1; i < N; i++) q_pos.push_back(i);
      m_vec = vec_in; m_sum = 0; m_valid = 0; m_have = 0;
    end else if (q_pos.size() != 0) begin
      int p;
      p = q_pos.pop_front();
      if (m_vec[p]) m_sum += p;
      m_valid = (q_pos.size() == 0);
      if (m_valid) m_have = 1;
    end else begin
      m_valid = 0;
    end
  end

  // Per-cycle comparison (R4 valid timing, R5/R3 held result, R9 quiet idle).
  always @(negedge clk) begin
    if (!rst) begin
      check(sum_valid == m_valid, "R4/R9 valid per cycle", sum_valid, m_valid);
      if (m_have)
        check(longint'(sum_out) == m_sum, "R5/R3 result per cycle", sum_out, m_sum);
    end
  end

  // Starts a scan; returns at the first negedge after the capturing edge.
  task automatic kick(input logic [N-1:0] v);
    @(negedge clk);
    start = 1'b1; vec_in = v;
    @(negedge clk);
    start = 1'b0; vec_in = ~v;   // R2: later input changes must be ignored
  endtask

  // Counts negedges (first after capture = 1) until valid is seen.
  task automatic await_valid(output int n);
    n = 1;
    while (!sum_valid && n < 3 * N) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic run_one(input logic [N-1:0] v, input string req);
    int n;
    longint exp;
    exp = soft_sum(v);
    kick(v);
    await_valid(n);
    check(n == N, "R4 latency", n, N);
    check(longint'(sum_out) == exp, req, sum_out, exp);
    @(negedge clk);
    check(sum_valid == 1'b0, "R4 single pulse", sum_valid, 0);
    repeat (4) @(negedge clk);
    check(longint'(sum_out) == exp, "R5 hold", sum_out, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sum_valid == 1'b0, "R1 reset valid", sum_valid, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(sum_valid == 1'b0, "R9 idle without start", sum_valid, 0);

    run_one('0, "R3 all zeros");
    run_one('1, "R3 all ones");
    check(soft_sum('1) == 522753, "R3 all-ones constant", soft_sum('1), 522753);
    begin
      logic [N-1:0] v;
      v = '0; v[0] = 1'b1;
      run_one(v, "R8 only bit 0");
      check(longint'(sum_out) == 0, "R8 bit 0 adds nothing", sum_out, 0);
      v = '0; v[N-1] = 1'b1;
      run_one(v, "R8 only top bit");
      check(longint'(sum_out) == N-1, "R8 top bit", sum_out, N-1);
      for (int i = 0; i < N; i++) v[i] = i[0];
      run_one(v, "R3 odd positions");
    end
    for (int k = 0; k < 6; k++) run_one(rand_vec(), "R3 random vector");

    // R6: abort in mid-scan.
    begin
      logic [N-1:0] a, b;
      int n;
      a = rand_vec(); b = rand_vec();
      kick(a);
      repeat (300) @(negedge clk);
      check(sum_valid == 1'b0, "R6 no valid mid-scan", sum_valid, 0);
      kick(b);
      await_valid(n);
      check(n == N, "R6 latency from restart", n, N);
      check(longint'(sum_out) == soft_sum(b), "R6 new vector sum", sum_out, soft_sum(b));
    end

    // R7: restart on the edge that would complete the scan.
    begin
      logic [N-1:0] a, b;
      int n;
      a = '1; b = rand_vec();
      kick(a);                          // now at negedge 1
      repeat (N - 3) @(negedge clk);    // now at negedge N-2
      @(negedge clk);                   // negedge N-1: drive restart
      start = 1'b1; vec_in = b;
      @(negedge clk);                   // negedge N: old scan would show valid
      start = 1'b0; vec_in = ~b;
      check(sum_valid == 1'b0, "R7 restart suppresses valid", sum_valid, 0);
      await_valid(n);
      check(n == N, "R7 latency after restart", n, N);
      check(longint'(sum_out) == soft_sum(b), "R7 new vector sum", sum_out, soft_sum(b));
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule